// File: doc/BRIEF.md
# Field-Aligned Layer Start and Buffer Selector

This block controls one display layer in an interlaced or progressive video pipeline. Software raises an enable bit, but the layer does not start straight away. The layer becomes active only at the start of a field whose parity matches a programmed start-field choice. Until that field arrives, the block reports that it is armed and waiting.

The block also picks which of two fetch descriptors, A or B, the layer's fetch engine uses for each field. It can follow field parity or stay on A. All decisions are registered on a one-cycle field-start pulse, so nothing changes in the middle of a field.

Two configuration bits, start-field and buffer-toggle, are captured on a load strobe. They reset to 1 and 0. The effective parity is the odd/even input in interlaced mode and is forced to 0 in progressive mode. An `odd_even` value of 1 means an odd field.

Top module: `layer_field_gate`

## Requirements
- R1: After reset, `layer_active`, `buf_sel_b` and `armed_wait` are 0. The stored start-field bit is 1 and the stored buffer-toggle bit is 0, so a progressive layer enabled without any configuration load starts at the first field start and fetches from A.
- R2: `layer_active` and `buf_sel_b` change only in the cycle after a clock edge at which `field_start` is 1. Changes on `odd_even` or `sw_enable` between field starts have no effect on these outputs.
- R3: At a field start, if `sw_enable` is 1, the layer is inactive, and (start-field XOR effective parity) is 1, then `layer_active` is 1 from the next cycle.
- R4: If that XOR is 0 at a field start, the layer stays inactive. It starts at the first later field start where the parity has changed.
- R5: In progressive mode (`interlaced`=0) the effective parity is 0 whatever `odd_even` is. With start-field 0 the layer never starts, and with start-field 1 it starts at the first field start.
- R6: When `sw_enable` is 0 at a field start, `layer_active` is 0 from the next cycle. Before that field start it keeps its value. Re-enabling waits for parity again, as in R3 and R4.
- R7: With buffer-toggle 1, each field start sets `buf_sel_b` to 1 (buffer B) when the effective parity is 0 (even field) and to 0 (buffer A) when it is 1 (odd field).
- R8: With buffer-toggle 0, every field start sets `buf_sel_b` to 0 (buffer A).
- R9: `armed_wait` is 1 exactly when `sw_enable` is 1 and `layer_active` is 0.
- R10: A one-cycle `cfg_load` pulse replaces both stored configuration bits. Once the layer is active, parity changes do not deactivate it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe that captures the two configuration bits |
| cfg_start_field | input | 1 | New start-field bit |
| cfg_buf_toggle | input | 1 | New buffer-toggle bit |
| sw_enable | input | 1 | Software layer enable |
| interlaced | input | 1 | 1 = interlaced, 0 = progressive |
| odd_even | input | 1 | Current field parity, 1 = odd |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| layer_active | output | 1 | Layer is being displayed |
| buf_sel_b | output | 1 | 1 = fetch buffer B, 0 = fetch buffer A |
| armed_wait | output | 1 | Enabled, but waiting for the matching field |

## Verification
A wrong active flag appears on `layer_active` and `armed_wait` one cycle after the field start that set it. It then persists for a whole field, so checks taken just after each pulse and again in mid-field catch both a wrong decision and a change outside a field start. A corrupted configuration bit shows at the next field start: the layer starts on the wrong parity, or `buf_sel_b` follows parity when it should not. The sweep covers every combination of mode, start-field and toggle bits against varying parity sequences.

// File: rtl/layer_field_gate.sv
module layer_field_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_load,
  input  logic cfg_start_field,
  input  logic cfg_buf_toggle,
  input  logic sw_enable,
  input  logic interlaced,
  input  logic odd_even,
  input  logic field_start,
  output logic layer_active,
  output logic buf_sel_b,
  output logic armed_wait
);

  logic cfg_start_q;
  logic cfg_tog_q;
  logic parity;
  logic start_ok;

  assign parity   = interlaced & odd_even;
  assign start_ok = cfg_start_q ^ parity;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_start_q <= 1'b1;
      cfg_tog_q   <= 1'b0;
    end else if (cfg_load) begin
      cfg_start_q <= cfg_start_field;
      cfg_tog_q   <= cfg_buf_toggle;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      layer_active <= 1'b0;
      buf_sel_b    <= 1'b0;
    end else if (field_start) begin
      buf_sel_b <= cfg_tog_q & ~parity;
      if (!sw_enable)
        layer_active <= 1'b0;
      else if (!layer_active && start_ok)
        layer_active <= 1'b1;
    end
  end

  assign armed_wait = sw_enable & ~layer_active;

endmodule

// File: rtl/layer_field_gate_chk.sv
module layer_field_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_enable,
  input logic interlaced,
  input logic odd_even,
  input logic field_start,
  input logic cfg_start_q,
  input logic cfg_tog_q,
  input logic layer_active,
  input logic buf_sel_b
);

  p_hold_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(layer_active));

  p_hold_buf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(buf_sel_b));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && sw_enable && (cfg_start_q ^ (interlaced & odd_even))) |=> layer_active);

  p_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !interlaced && !cfg_start_q && !layer_active) |=> !layer_active);

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !sw_enable) |=> !layer_active);

  p_bufa_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !cfg_tog_q) |=> !buf_sel_b);

  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_active && sw_enable) |=> layer_active);

endmodule

bind layer_field_gate layer_field_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .interlaced(interlaced),
  .odd_even(odd_even), .field_start(field_start), .cfg_start_q(cfg_start_q),
  .cfg_tog_q(cfg_tog_q), .layer_active(layer_active), .buf_sel_b(buf_sel_b)
);

// File: tb/layer_field_gate_test.sv
module layer_field_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_start_field = 1'b0, cfg_buf_toggle = 1'b0;
  logic sw_enable = 1'b0, interlaced = 1'b0, odd_even = 1'b0, field_start = 1'b0;
  logic layer_active, buf_sel_b, armed_wait;

  int n_chk = 0;
  int n_bad = 0;
  logic m_s = 1'b1, m_t = 1'b0, e_act = 1'b0, e_b = 1'b0;

  always #4 clk = ~clk;

  layer_field_gate uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_start_field(cfg_start_field),
    .cfg_buf_toggle(cfg_buf_toggle), .sw_enable(sw_enable), .interlaced(interlaced),
    .odd_even(odd_even), .field_start(field_start), .layer_active(layer_active),
    .buf_sel_b(buf_sel_b), .armed_wait(armed_wait)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " layer_active"}, layer_active, e_act);
    chk({tag, " buf_sel_b"}, buf_sel_b, e_b);
    chk({tag, " armed_wait R9"}, armed_wait, sw_enable & ~e_act);
  endtask

  task automatic load_cfg(input logic s, input logic t);
    @(negedge clk);
    cfg_start_field = s; cfg_buf_toggle = t; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; cfg_start_field = ~s; cfg_buf_toggle = ~t;
    m_s = s; m_t = t;
  endtask

  task automatic field(input logic oe, input string tag);
    logic p;
    @(negedge clk);
    check_all({tag, " pre-field R2 R6"});
    odd_even = oe; field_start = 1'b1;
    p = interlaced & oe;
    e_b = m_t & ~p;
    if (!sw_enable) e_act = 1'b0;
    else if (!e_act && (m_s ^ p)) e_act = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    check_all({tag, " post-field R3 R4 R5 R7 R8 R10"});
    odd_even = ~oe;
    @(negedge clk);
    check_all({tag, " mid-field R2"});
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    sw_enable = 1'b1; interlaced = 1'b0;
    field(1'b1, "R1 default start progressive");
    interlaced = 1'b1;
    field(1'b0, "R1 default toggle gives A");
    sw_enable = 1'b0;
    field(1'b0, "R6 drop");

    for (int il = 0; il < 2; il++)
      for (int s = 0; s < 2; s++)
        for (int t = 0; t < 2; t++)
          for (int pat = 0; pat < 4; pat++) begin
            interlaced = il[0];
            load_cfg(s[0], t[0]);
            sw_enable = 1'b0;
            field(1'b0, "R6 clear");
            @(negedge clk);
            sw_enable = 1'b1;
            @(negedge clk);
            check_all("R9 armed before field");
            for (int f = 0; f < 6; f++) begin
              logic oe;
              oe = (pat == 0) ? f[0] : (pat == 1) ? 1'b1 : (pat == 2) ? 1'b0 : (f[1] ^ f[0]);
              field(oe, "R4 R7 sweep");
            end
            sw_enable = 1'b0;
            @(negedge clk);
            check_all("R6 hold until field start");
            field(1'b1, "R6 disable");
            sw_enable = 1'b1;
            field(1'b1, "R6 re-enable");
            field(1'b0, "R6 re-enable next");
          end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule